// File: doc/BRIEF.md
# Framed parallel word transmitter with host ready gating

This block sends a stream of 16-bit words to a host across a parallel port. The port clock is free-running and comes from outside; the block never gates or produces it. Words come in on a valid/ready stream. They go out one per port-clock cycle on a data bus. A one-cycle frame strobe marks the first word of each frame.

The host throttles the link with a ready line. That line passes through a synchronizer and is looked at only between frames. While it is inactive, the block stays idle: the bus is held at zero and the strobe is inactive. Once a frame has started, it always runs to the length latched at its start. The length is from 1 to 32768 words, and a programmed value of zero means 32768.

If the input stream runs dry mid-frame, the last word stays on the bus and the count pauses. A sticky underrun flag is raised at the same time. The active level of the frame strobe and of the host ready line are run-time inputs. A build parameter chooses which edge of the port clock the logic runs on.

Top module: `pframe_tx`

## Requirements
- R1: While reset is low, after at least one clock edge, `pd_out` is zero, `fs_out` is at its inactive level, `s_ready` is low and `underrun` is low.
- R2: While the synchronized host ready is inactive and no frame is running, `s_ready` stays low, `pd_out` stays zero and `fs_out` stays inactive, whatever `s_valid` does.
- R3: `fs_out` is active for exactly one cycle per frame, in the same cycle as the frame's first word on `pd_out`.
- R4: A frame carries exactly the latched number of words, in the order accepted, each word on `pd_out` the cycle after its handshake. `s_ready` is low while the last word is shown. The following cycle shows zero on `pd_out` with `fs_out` inactive.
- R5: A programmed length of 0 produces a frame of 32768 words.
- R6: Deasserting the host ready line during a frame does not shorten or pause that frame. No further frame starts until it is ready again.
- R7: A mid-frame cycle without `s_valid` holds the previous word on `pd_out`, does not advance the count and sets `underrun`. `underrun` stays set until the next frame starts, and is low in that frame's first word.
- R8: With `fs_pol_hi` = 1, the strobe is high when active and low when idle. With `fs_pol_hi` = 0, it is low when active and high when idle.
- R9: With `mr_pol_hi` = 1, a high `mr_pin` means ready. With `mr_pol_hi` = 0, a low `mr_pin` means ready.
- R10: A change on `mr_pin` reaches `s_ready` in the idle state after two clock edges, not one.
- R11: `cfg_len` is latched at frame start. Changing it mid-frame does not change the length of the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| port_clk | input | 1 | Free-running external port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len | input | 15 | Words per frame, 0 means 32768 |
| fs_pol_hi | input | 1 | 1: frame strobe active high |
| mr_pol_hi | input | 1 | 1: host ready line active high |
| mr_pin | input | 1 | Host ready line, asynchronous |
| s_valid | input | 1 | Input word valid |
| s_data | input | 16 | Input word |
| s_ready | output | 1 | Block accepts the input word this cycle |
| pd_out | output | 16 | Parallel data bus |
| fs_out | output | 1 | Frame strobe, first word of each frame |
| underrun | output | 1 | Sticky: stream ran dry inside a frame |

## Verification
The assertions assume that `fs_pol_hi` changes only while no frame is running. Otherwise a level flip would look like a strobe, and the bench changes polarity only in idle gaps. They also assume `s_data` is stable across the sampling edge. The bench drives every input on the falling edge, so that holds.

A word-sequence check uses incrementing data, so a dropped, repeated or reordered word shows as a mismatch. Stalls are injected only before a frame's final word, so each one is a true mid-frame underrun.

// File: rtl/pframe_pkg.sv
// Shared types for the framed parallel transmitter.
package pframe_pkg;
    // Sequencer state: waiting between frames, or streaming a frame.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/pframe_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes STAGES >= 2; output resets to 0 (the "not ready" level).
module pframe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pframe_len.sv
// Decodes the programmed frame length into a word count.
// Assumes a zero field means the largest frame, 2**LEN_W words.
module pframe_len #(
    parameter int LEN_W = 15
) (
    input  logic [LEN_W-1:0] cfg,
    output logic [LEN_W:0]   words
);
    // Zero maps to the full-size frame; other values pass through.
    always_comb begin
        if (cfg == '0) words = {1'b1, {LEN_W{1'b0}}};
        else           words = {1'b0, cfg};
    end
endmodule

// File: rtl/pframe_seq.sv
// Frame sequencer: starts frames when ready, counts words, handles stalls.
// Assumes mr_ok is already synchronized and frame_words is in 1..2**(CNT_W-1).
module pframe_seq
    import pframe_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mr_ok,
    input  logic [CNT_W-1:0]  frame_words,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              strobe,
    output logic              underrun
);
    seq_state_e       st;
    logic [CNT_W-1:0] sent_q;
    logic [CNT_W-1:0] len_q;
    logic             last_sent;
    logic             take;

    // Frame is complete once the latched count has gone out.
    assign last_sent = (sent_q == len_q);

    // Accept between frames only when host is ready; inside a frame until full.
    always_comb begin
        if (st == ST_IDLE) in_ready = mr_ok;
        else               in_ready = !last_sent;
    end

    assign take = in_valid && in_ready;

    // State, count, output word, strobe and underrun updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            sent_q   <= '0;
            len_q    <= '0;
            out_data <= '0;
            strobe   <= 1'b0;
            underrun <= 1'b0;
        end else begin
            strobe <= 1'b0;
            case (st)
                ST_IDLE: begin
                    out_data <= '0;
                    if (take) begin
                        st       <= ST_RUN;
                        out_data <= in_data;
                        strobe   <= 1'b1;
                        sent_q   <= CNT_W'(1);
                        len_q    <= frame_words;
                        underrun <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (last_sent) begin
                        st       <= ST_IDLE;
                        out_data <= '0;
                    end else if (take) begin
                        out_data <= in_data;
                        sent_q   <= sent_q + CNT_W'(1);
                    end else begin
                        underrun <= 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pframe_tx.sv
// Top level of the framed parallel transmitter.
// Assumes port_clk is free-running; CLK_FALL picks the active edge at build time.
module pframe_tx #(
    parameter int DATA_W      = 16,
    parameter int LEN_W       = 15,
    parameter int SYNC_STAGES = 2,
    parameter bit CLK_FALL    = 1'b0
) (
    input  logic              port_clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              fs_pol_hi,
    input  logic              mr_pol_hi,
    input  logic              mr_pin,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic [DATA_W-1:0] pd_out,
    output logic              fs_out,
    output logic              underrun
);
    localparam int CNT_W = LEN_W + 1;

    logic             core_clk;
    logic             mr_norm;
    logic             mr_ok;
    logic             strobe;
    logic [CNT_W-1:0] frame_words;

    // Select the active clock edge.
    generate
        if (CLK_FALL) begin : g_fall_edge
            assign core_clk = ~port_clk;
        end else begin : g_rise_edge
            assign core_clk = port_clk;
        end
    endgenerate

    // Fold the ready polarity in before synchronizing, so reset means not ready.
    assign mr_norm = ~(mr_pin ^ mr_pol_hi);

    pframe_sync #(.STAGES(SYNC_STAGES)) u_mr_sync (
        .clk   (core_clk),
        .rst_n (rst_n),
        .d     (mr_norm),
        .q     (mr_ok)
    );

    pframe_len #(.LEN_W(LEN_W)) u_len (
        .cfg   (cfg_len),
        .words (frame_words)
    );

    pframe_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk         (core_clk),
        .rst_n       (rst_n),
        .mr_ok       (mr_ok),
        .frame_words (frame_words),
        .in_valid    (s_valid),
        .in_data     (s_data),
        .in_ready    (s_ready),
        .out_data    (pd_out),
        .strobe      (strobe),
        .underrun    (underrun)
    );

    // Drive the strobe pin at the programmed active level.
    assign fs_out = strobe ? fs_pol_hi : ~fs_pol_hi;
endmodule

// File: rtl/pframe_tx_chk.sv
// Protocol checker for pframe_tx, attached by bind.
// Assumes fs_pol_hi changes only between frames.
module pframe_tx_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fs_pol_hi,
    input logic              fs_out,
    input logic              s_valid,
    input logic              s_ready,
    input logic [DATA_W-1:0] s_data,
    input logic [DATA_W-1:0] pd_out,
    input logic              underrun
);
    logic fs_on;
    assign fs_on = (fs_out == fs_pol_hi);

    // R3
    fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_on |=> !fs_on);

    // R3
    fs_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_on |-> $past(s_valid && s_ready));

    // R4
    word_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (pd_out == $past(s_data)));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && !s_valid) |=> $stable(pd_out));

    // R7
    underrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_on |-> !underrun);
endmodule

bind pframe_tx pframe_tx_chk #(.DATA_W(DATA_W)) u_pframe_chk (
    .clk       (core_clk),
    .rst_n     (rst_n),
    .fs_pol_hi (fs_pol_hi),
    .fs_out    (fs_out),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .pd_out    (pd_out),
    .underrun  (underrun)
);

// File: tb/pframe_tx_test.sv
`timescale 1ns/1ps
module pframe_tx_test;
    localparam int MAX_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] cfg_len;
    logic        fs_pol_hi;
    logic        mr_pol_hi;
    logic        mr_pin;
    logic        s_valid;
    logic [15:0] s_data;
    logic        s_ready;
    logic [15:0] pd_out;
    logic        fs_out;
    logic        underrun;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    pframe_tx uut (
        .port_clk  (clk),
        .rst_n     (rst_n),
        .cfg_len   (cfg_len),
        .fs_pol_hi (fs_pol_hi),
        .mr_pol_hi (mr_pol_hi),
        .mr_pin    (mr_pin),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_ready   (s_ready),
        .pd_out    (pd_out),
        .fs_out    (fs_out),
        .underrun  (underrun)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One frame of n words from base, with optional stall, ready drop, length change.
    task automatic run_frame(input int cfg, input int n, input logic [15:0] base,
                             input int stall_at, input int mr_drop_at,
                             input int chg_at, input string req);
        int          bad = 0;
        int          fs_bad = 0;
        bit          und_bad = 1'b0;
        bit          tail_bad = 1'b0;
        logic [15:0] first_act = '0;
        logic [15:0] first_exp = '0;
        @(negedge clk);
        cfg_len = cfg[14:0];
        s_valid = 1'b1;
        s_data  = base;
        for (int i = 0; i < n; i++) begin
            logic [15:0] exp_w;
            exp_w = base + 16'(i);
            @(negedge clk);
            if (pd_out !== exp_w) begin
                if (bad == 0) begin first_act = pd_out; first_exp = exp_w; end
                bad++;
            end
            if (fs_out !== ((i == 0) ? fs_pol_hi : ~fs_pol_hi)) fs_bad++;
            if (i == 0 && underrun !== 1'b0) und_bad = 1'b1;
            if (i == n - 1 && s_ready !== 1'b0) tail_bad = 1'b1;
            if (i == stall_at) begin
                s_valid = 1'b0;
                @(negedge clk);
                // R7: stall holds word, raises underrun
                chk(pd_out === exp_w && underrun === 1'b1 && fs_out === ~fs_pol_hi,
                    "R7", "stall hold", {pd_out, 7'd0, underrun}, {exp_w, 8'd1});
                s_valid = 1'b1;
            end
            if (i == mr_drop_at) mr_pin = ~mr_pol_hi;
            if (i == chg_at) cfg_len = 15'd1;
            s_data = base + 16'(i + 1);
        end
        @(negedge clk);
        s_valid = 1'b0;
        chk(bad == 0, req, "word sequence", first_act, first_exp);
        // R3: strobe only on first word
        chk(fs_bad == 0, "R3", "strobe placement", fs_bad, 0);
        // R7: underrun clear at frame start
        chk(!und_bad, "R7", "underrun cleared at start", und_bad, 0);
        // R4: no extra word taken, then idle output
        chk(!tail_bad, "R4", "ready low on last word", tail_bad, 0);
        chk(pd_out === 16'h0 && fs_out === ~fs_pol_hi, "R4", "idle after frame",
            pd_out, 0);
    endtask

    task automatic test_reset();
        repeat (4) @(negedge clk);
        // R1
        chk(pd_out === 16'h0 && fs_out === 1'b0 && s_ready === 1'b0 && underrun === 1'b0,
            "R1", "reset state", {pd_out, fs_out, s_ready, underrun}, 0);
        rst_n = 1'b1;
    endtask

    task automatic test_ready_block();
        mr_pin  = 1'b0;
        s_valid = 1'b1;
        s_data  = 16'hABCD;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            // R2
            chk(s_ready === 1'b0 && pd_out === 16'h0 && fs_out === ~fs_pol_hi,
                "R2", "blocked while not ready", {s_ready, pd_out}, 0);
        end
        s_valid = 1'b0;
    endtask

    task automatic test_sync_latency();
        @(negedge clk);
        mr_pin = mr_pol_hi;
        @(negedge clk);
        // R10: one edge is not enough
        chk(s_ready === 1'b0, "R10", "ready after one edge", s_ready, 0);
        @(negedge clk);
        // R10: visible after two edges
        chk(s_ready === 1'b1, "R10", "ready after two edges", s_ready, 1);
    endtask

    task automatic test_basic();
        run_frame(4, 4, 16'h1000, -1, -1, -1, "R4");
        run_frame(1, 1, 16'h2000, -1, -1, -1, "R4");
    endtask

    task automatic test_underrun();
        run_frame(6, 6, 16'h3000, 2, -1, -1, "R7");
        @(negedge clk);
        // R7: flag sticky between frames
        chk(underrun === 1'b1, "R7", "underrun sticky", underrun, 1);
        run_frame(2, 2, 16'h3100, -1, -1, -1, "R7");
        // R7: cleared by the new frame
        chk(underrun === 1'b0, "R7", "underrun after clean frame", underrun, 0);
    endtask

    task automatic test_ready_drop();
        run_frame(8, 8, 16'h4000, -1, 2, -1, "R6");
        s_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R6: no new frame once ready is gone
        chk(s_ready === 1'b0 && pd_out === 16'h0, "R6", "no restart while not ready",
            {s_ready, pd_out}, 0);
        s_valid = 1'b0;
        mr_pin = mr_pol_hi;
        repeat (3) @(negedge clk);
    endtask

    task automatic test_len_latch();
        run_frame(5, 5, 16'h5000, -1, -1, 1, "R11");
    endtask

    task automatic test_fs_polarity();
        @(negedge clk);
        fs_pol_hi = 1'b0;
        @(negedge clk);
        // R8: inactive level high when active low
        chk(fs_out === 1'b1, "R8", "idle level inverted", fs_out, 1);
        run_frame(3, 3, 16'h6000, -1, -1, -1, "R8");
        fs_pol_hi = 1'b1;
    endtask

    task automatic test_mr_polarity();
        @(negedge clk);
        mr_pol_hi = 1'b0;
        mr_pin    = 1'b1;
        repeat (3) @(negedge clk);
        // R9: high pin is not ready when active low
        chk(s_ready === 1'b0, "R9", "high pin not ready", s_ready, 0);
        mr_pin = 1'b0;
        repeat (3) @(negedge clk);
        // R9: low pin is ready when active low
        chk(s_ready === 1'b1, "R9", "low pin ready", s_ready, 1);
        run_frame(2, 2, 16'h7000, -1, -1, -1, "R9");
        mr_pol_hi = 1'b1;
        mr_pin    = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic test_max_len();
        run_frame(0, 32768, 16'h0000, -1, -1, -1, "R5");
    endtask

    initial begin
        rst_n     = 1'b0;
        cfg_len   = 15'd4;
        fs_pol_hi = 1'b1;
        mr_pol_hi = 1'b1;
        mr_pin    = 1'b0;
        s_valid   = 1'b0;
        s_data    = 16'h0;
        test_reset();
        test_ready_block();
        test_sync_latency();
        test_basic();
        test_underrun();
        test_ready_drop();
        test_len_latch();
        test_fs_polarity();
        test_mr_polarity();
        test_max_len();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(MAX_CYC * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule